// File: doc/BRIEF.md
# CAN frame transmit-FIFO byte serializer

This block turns one CAN frame, presented on a valid/ready input, into the exact byte sequence a host must shift into the transmit FIFO of a serial-attached CAN controller. The sequence starts with a write-FIFO opcode and a tag byte. The identifier follows, packed with its flag bits; then the length byte and the payload. Each byte leaves on a valid/ready output with a last marker on the final byte. A downstream serial-port engine consumes this output.

The identifier is spread over two bytes for a standard frame and over four bytes for an extended frame. The extended form carries fixed substitute-remote and identifier-extension bits. Because of this, and because the payload length varies, the stream is between 5 and 15 bytes long. The block holds one frame at a time. It refuses a new frame until the last byte of the current one has been taken.

Top module: `can_fifo_ser`

## Requirements
- R1: After reset `in_ready_o` is high. A frame is captured on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` then stays low until the edge that hands off the final byte, and it is high again in the following cycle.
- R2: Stream byte 0 is the opcode 0x12 and stream byte 1 is the tag 0x00.
- R3: For a standard frame (`in_ext_i`=0), stream byte 2 is id[10:3]. Stream byte 3 holds id[2:0] in bits 7:5, the remote flag in bit 4 and zeros in bits 3:0. Identifier bits above 10 are not used.
- R4: For an extended frame, stream byte 2 is id[28:21]. Stream byte 3 holds id[20:18] in bits 7:5, ones in bits 4 and 3, and id[17:15] in bits 2:0. Stream byte 4 is id[14:7]. Stream byte 5 holds id[6:0] in bits 7:1 and the remote flag in bit 0.
- R5: The length byte follows the identifier bytes, at stream byte 4 for a standard frame and stream byte 6 for an extended frame. It carries the effective length L. After it come L payload bytes, payload byte i being `in_data_i[8*i+7:8*i]`, in increasing i. The remote flag does not suppress the payload.
- R6: A length field above 8 is treated as 8, both in the length byte and in the payload count.
- R7: A standard frame's stream is 5+L bytes and an extended frame's is 7+L bytes. After the final byte `out_valid_o` is low.
- R8: `out_last_o` is high exactly while the final byte of the stream is presented.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the byte and the last flag are held unchanged on the next cycle.
- R10: Input frames offered while a stream is in progress are ignored, and the stream in progress is unchanged.
- R11: After reset `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Frame offered |
| in_ready_o | output | 1 | Serializer idle, frame can be taken |
| in_ext_i | input | 1 | 1: 29-bit identifier, 0: 11-bit identifier |
| in_rtr_i | input | 1 | Remote request flag |
| in_id_i | input | 29 | Identifier, right-aligned |
| in_len_i | input | 4 | Payload length, values above 8 clamp to 8 |
| in_data_i | input | 64 | Payload, byte i at bits 8i+7:8i |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Downstream takes the byte |
| out_byte_o | output | 8 | Stream byte |
| out_last_o | output | 1 | Final byte of the stream |

## Verification
The assertions check four things on every cycle: a captured frame always opens with the opcode byte, a stalled byte and its last flag stay put, the last handshake always ends the stream, and the final byte falls inside the legal length window. Only the bench scenarios can show that every identifier bit lands in the right place for both formats. The same goes for the payload order, the clamp of oversize lengths, and the exact stream length. They also show that frames offered mid-stream leave the output untouched, using random backpressure and offered junk frames.

// File: rtl/can_ser_pkg.sv
package can_ser_pkg;
  localparam int ID_W        = 29;
  localparam int DATA_BYTES  = 8;
  localparam int LEN_W       = 4;
  localparam int BYTE_W      = 8;
  localparam int STD_DLC_IDX = 4;
  localparam int EXT_DLC_IDX = 6;
  localparam int STREAM_MAX  = EXT_DLC_IDX + DATA_BYTES + 1;
  localparam int CNT_W       = $clog2(STREAM_MAX);

  localparam logic [BYTE_W-1:0] OPC_WR_FIFO = 8'h12;
  localparam logic [BYTE_W-1:0] TAG_BYTE    = 8'h00;
  localparam logic [BYTE_W-1:0] EXT_FLAGS   = 8'h18;

  typedef struct packed {
    logic                         ext;
    logic                         rtr;
    logic [ID_W-1:0]              id;
    logic [LEN_W-1:0]             len;
    logic [DATA_BYTES*BYTE_W-1:0] data;
  } frame_t;

  typedef logic [STREAM_MAX-1:0][BYTE_W-1:0] stream_t;
endpackage

// File: rtl/can_ser_pack.sv
module can_ser_pack
  import can_ser_pkg::*;
(
  input  frame_t           frame_i,
  output stream_t          stream_o,
  output logic [CNT_W-1:0] last_idx_o
);
  logic [BYTE_W-1:0] dat [DATA_BYTES];

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_dat
    assign dat[g] = (LEN_W'(g) < frame_i.len) ? frame_i.data[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    stream_o    = '0;
    stream_o[0] = OPC_WR_FIFO;
    stream_o[1] = TAG_BYTE;
    if (frame_i.ext) begin
      stream_o[2] = frame_i.id[28:21];
      stream_o[3] = {frame_i.id[20:18], 5'b0} | EXT_FLAGS | {5'b0, frame_i.id[17:15]};
      stream_o[4] = frame_i.id[14:7];
      stream_o[5] = {frame_i.id[6:0], frame_i.rtr};
      stream_o[EXT_DLC_IDX] = BYTE_W'(frame_i.len);
      for (int i = 0; i < DATA_BYTES; i++) stream_o[EXT_DLC_IDX+1+i] = dat[i];
      last_idx_o = CNT_W'(EXT_DLC_IDX) + CNT_W'(frame_i.len);
    end else begin
      stream_o[2] = frame_i.id[10:3];
      stream_o[3] = {frame_i.id[2:0], frame_i.rtr, 4'b0};
      stream_o[STD_DLC_IDX] = BYTE_W'(frame_i.len);
      for (int i = 0; i < DATA_BYTES; i++) stream_o[STD_DLC_IDX+1+i] = dat[i];
      last_idx_o = CNT_W'(STD_DLC_IDX) + CNT_W'(frame_i.len);
    end
  end
endmodule

// File: rtl/can_ser_ctrl.sv
module can_ser_ctrl
  import can_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  frame_t           frame_i,
  output logic             in_ready_o,
  input  logic [CNT_W-1:0] last_idx_i,
  input  logic             out_ready_i,
  output frame_t           frame_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_BYTES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  frame_t           frame_q;
  logic             at_last;

  assign at_last    = (cnt_q == last_idx_i);
  assign in_ready_o = !busy_q;
  assign busy_o     = busy_q;
  assign cnt_o      = cnt_q;
  assign frame_o    = frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      frame_q <= '0;
    end else if (!busy_q) begin
      if (in_valid_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        frame_q <= frame_i;
        if (frame_i.len > LEN_MAX) frame_q.len <= LEN_MAX;  // clamp oversize length
      end
    end else if (out_ready_i) begin
      if (at_last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r1_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && out_ready_i && at_last |=> in_ready_o);

  a_r10_frame_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(out_ready_i && at_last) |=> $stable(frame_q));
endmodule

// File: rtl/can_fifo_ser.sv
module can_fifo_ser
  import can_ser_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  output logic                         in_ready_o,
  input  logic                         in_ext_i,
  input  logic                         in_rtr_i,
  input  logic [ID_W-1:0]              in_id_i,
  input  logic [LEN_W-1:0]             in_len_i,
  input  logic [DATA_BYTES*BYTE_W-1:0] in_data_i,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [BYTE_W-1:0]            out_byte_o,
  output logic                         out_last_o
);
  frame_t           frame_in, frame_q;
  stream_t          stream;
  logic [CNT_W-1:0] last_idx, cnt;
  logic             busy;

  assign frame_in = '{ext: in_ext_i, rtr: in_rtr_i, id: in_id_i, len: in_len_i, data: in_data_i};

  can_ser_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .frame_i    (frame_in),
    .in_ready_o (in_ready_o),
    .last_idx_i (last_idx),
    .out_ready_i(out_ready_i),
    .frame_o    (frame_q),
    .busy_o     (busy),
    .cnt_o      (cnt)
  );

  can_ser_pack u_pack (
    .frame_i   (frame_q),
    .stream_o  (stream),
    .last_idx_o(last_idx)
  );

  assign out_valid_o = busy;
  assign out_byte_o  = stream[cnt];
  assign out_last_o  = busy && (cnt == last_idx);

  a_r2_opcode_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && out_byte_o == OPC_WR_FIFO);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o) && $stable(out_last_o));

  a_r8_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);

  a_r7_len_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> (cnt >= CNT_W'(STD_DLC_IDX) && cnt <= CNT_W'(STREAM_MAX - 1)));
endmodule

// File: tb/can_fifo_ser_bench.sv
module can_fifo_ser_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        in_ext_i = 1'b0;
  logic        in_rtr_i = 1'b0;
  logic [28:0] in_id_i = '0;
  logic [3:0]  in_len_i = '0;
  logic [63:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_byte_o;
  logic        out_last_o;

  int total = 0;
  int fails = 0;
  logic [7:0] exp_b [15];
  int exp_n;

  always #10 clk_i = ~clk_i;

  can_fifo_ser u_can_fifo_ser (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(input bit ext, input bit rtr, input logic [28:0] id,
                           input int len, input logic [63:0] data);
    int l;
    int base;
    l = (len > 8) ? 8 : len;
    exp_b[0] = 8'h12;
    exp_b[1] = 8'h00;
    if (ext) begin
      exp_b[2] = id[28:21];
      exp_b[3] = {id[20:18], 2'b11, id[17:15]};
      exp_b[4] = id[14:7];
      exp_b[5] = {id[6:0], rtr};
      base = 6;
    end else begin
      exp_b[2] = id[10:3];
      exp_b[3] = {id[2:0], rtr, 4'b0000};
      base = 4;
    end
    exp_b[base] = 8'(l);
    for (int i = 0; i < l; i++) exp_b[base+1+i] = data[8*i +: 8];
    exp_n = base + 1 + l;
  endtask

  function automatic string tag_of(input bit ext, input int idx, input string dtag);
    if (idx < 2) return "R2";
    if (ext && idx < 6) return "R4";
    if (!ext && idx < 4) return "R3";
    return dtag;
  endfunction

  task automatic run_frame(input bit ext, input bit rtr, input logic [28:0] id,
                           input int len, input logic [63:0] data, input string dtag);
    int idx;
    bit rdy;
    build_exp(ext, rtr, id, len, data);
    @(negedge clk_i);
    in_ext_i = ext; in_rtr_i = rtr; in_id_i = id; in_len_i = 4'(len); in_data_i = data;
    in_valid_i = 1'b1;
    #1 check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    // junk offered while busy, must be ignored (R10)
    in_ext_i = 1'($urandom); in_rtr_i = 1'($urandom); in_id_i = 29'($urandom);
    in_len_i = 4'($urandom); in_data_i = {$urandom, $urandom};
    idx = 0;
    while (idx < exp_n) begin
      rdy = ($urandom % 4) != 0;
      out_ready_i = rdy;
      #1;
      check(out_valid_o == 1'b1, "R9", int'(out_valid_o), 1);
      check(in_ready_o == 1'b0, "R1 R10", int'(in_ready_o), 0);
      check(out_byte_o == exp_b[idx], {tag_of(ext, idx, dtag), " R10"}, int'(out_byte_o), int'(exp_b[idx]));
      check(out_last_o == (idx == exp_n - 1), "R8", int'(out_last_o), int'(idx == exp_n - 1));
      if (rdy) begin
        if (idx == exp_n - 1) in_valid_i = 1'b0;
        idx++;
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
    out_ready_i = 1'b0;
    #1;
    check(out_valid_o == 1'b0, "R7", int'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #35;
    check(out_valid_o == 1'b0, "R11", int'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1", int'(in_ready_o), 1);
    rst_ni = 1'b1;
    // directed corners
    run_frame(1'b0, 1'b0, 29'h1FFFF800 | 29'h5A5, 0, 64'h0, "R5");
    run_frame(1'b0, 1'b1, 29'h7FF, 8, 64'h8877665544332211, "R5");
    run_frame(1'b1, 1'b0, 29'h1FFFFFFF, 8, 64'hF0E1D2C3B4A59687, "R5");
    run_frame(1'b1, 1'b1, 29'h12345678, 3, 64'hDEADBEEFCAFEF00D, "R5");
    run_frame(1'b1, 1'b0, 29'h0, 0, 64'h0, "R5");
    run_frame(1'b0, 1'b0, 29'h123, 15, 64'h0102030405060708, "R6");
    run_frame(1'b1, 1'b0, 29'h0ABCDEF1, 9, 64'hA1A2A3A4A5A6A7A8, "R6");
    // random frames
    for (int n = 0; n < 60; n++) begin
      int len;
      len = int'($urandom % 16);
      run_frame(1'($urandom), 1'($urandom), 29'($urandom), len, {$urandom, $urandom},
                (len > 8) ? "R6" : "R5");
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule